// File: doc/BRIEF.md
# Serial Port Transfer and Error Status Unit

This block holds the status byte of an asynchronous serial port that runs either with a one-entry transmit buffer or with a transmit FIFO. Bit 7 reports whether transmit data is still pending. Data counts as pending when the shift register holds a byte or the holding stage is not empty. In single mode the holding stage is one data register. In FIFO mode it is the transmit FIFO. Bits 3 to 0 are sticky receive error flags.

The shifters, the baud generator and the FIFO storage sit outside the block. They reach it as one-cycle event pulses:
- a byte written for transmission;
- a byte moved into the shift register;
- the shift register emptied;
- parity, framing and overrun errors from the receiver;
- a receive push together with the receive FIFO's full indication.

Software writes the byte either as a whole or one bit at a time, through a write strobe, a bit-mode select, a bit index and write data. The byte itself is presented continuously on an output.

When a received byte arrives in FIFO mode while the receive FIFO is full, the block raises the overflow flag. In the same cycle it asserts a suppress output, so the FIFO discards the byte.

Top module: `sio_status_unit`

## Requirements
- R1: After reset the status byte reads 0x00. Bits 6 to 4 always read 0, even after a write of ones to them.
- R2: Error flag positions are: bit 3 overflow, bit 2 parity, bit 1 framing, bit 0 overrun. While power and receive enable are both 1, an error pulse sets its flag at the next clock edge. A flag stays set across later cycles with no error until software or a control bit clears it.
- R3: If power is 0 or receive enable is 0 at a clock edge, all four error flags are 0 after that edge. Error pulses that arrive while either bit is 0 set nothing.
- R4: A byte write (strobe 1, bit mode 0) clears each error flag whose write data bit is 0 and leaves each flag whose write data bit is 1 unchanged. Write data bits 7 to 4 have no effect, so writing 0x00 clears all four flags.
- R5: A single-bit write (strobe 1, bit mode 1) takes its value from write data bit 0. If the index is 0 to 3 and the value is 0, only that flag is cleared. A value of 1, or an index of 4 to 7, changes nothing.
- R6: If an error pulse and a software clear of the same flag arrive in the same cycle, the flag is 1 after the edge.
- R7: In single mode (mode input 0) the overflow flag is never set, and the suppress output stays 0 even when a push meets a full receive FIFO.
- R8: In FIFO mode, with power and receive enable at 1, a push while the receive FIFO is full asserts the suppress output in that same cycle. The overflow flag is set at the next edge.
- R9: A transmit write that is sampled at clock edge n first shows as bit 7 = 1 after edge n+2. Bit 7 is 0 after edges n and n+1.
- R10: Bit 7 is 1 while the shift register is busy or the holding stage holds data. It returns to 0 after the shift-done pulse once the holding stage is empty.
- R11: Bit 7 reads 0 in any cycle where power or transmit enable is 0. Every pending transmit entry, including writes still in the two-cycle lag, is discarded at the next edge.
- R12: The holding stage takes one entry in single mode and TX_FIFO_DEPTH entries in FIFO mode. Writes that arrive when it is full are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Power control bit |
| tx_en | input | 1 | Transmit enable control bit |
| rx_en | input | 1 | Receive enable control bit |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = single mode |
| tx_wr | input | 1 | Pulse: byte written for transmission |
| tx_start | input | 1 | Pulse: holding entry moved into the shift register |
| tx_end | input | 1 | Pulse: shift register emptied |
| rx_par_err | input | 1 | Pulse: parity error on a received frame |
| rx_frm_err | input | 1 | Pulse: framing error on a received frame |
| rx_ovr_err | input | 1 | Pulse: overrun error on a received frame |
| rx_push | input | 1 | Receiver wants to push a byte into the receive FIFO |
| rx_full | input | 1 | Receive FIFO is full |
| reg_wr | input | 1 | Software write strobe |
| reg_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| reg_sel | input | 3 | Bit index for single-bit writes |
| reg_wdata | input | 8 | Write data (bit 0 is the value in bit mode) |
| stat_o | output | 8 | Status byte |
| push_block_o | output | 1 | Suppress the current receive FIFO write |

## Verification
The suppress output and the forced-zero of bit 7 are combinational, so the bench checks them in the same cycle as their stimulus, after the inputs settle. Error flags and software writes take effect one edge after they are sampled. For these, the bench drives at the falling edge and checks at the next falling edge. The transmit lag is checked at both intermediate edges and at the edge where it must resolve: after edges n and n+1 the bench expects 0, and after edge n+2 it expects 1. Byte writes are swept over all sixteen error-bit patterns, and single-bit writes over every index with both values.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;

    localparam int STAT_W   = 8;
    localparam int ERR_W    = 4;
    localparam int BUSY_BIT = 7;

    // Packed order gives the bit positions of the status byte's low nibble.
    typedef struct packed {
        logic ovf;   // bit 3
        logic par;   // bit 2
        logic frm;   // bit 1
        logic ovr;   // bit 0
    } err_flags_t;

endpackage

// File: rtl/sio_err_flags.sv
module sio_err_flags
    import sio_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en,
    input  logic       rx_en,
    input  logic       fifo_mode,
    input  logic       ev_par,
    input  logic       ev_frm,
    input  logic       ev_ovr,
    input  logic       rx_push,
    input  logic       rx_full,
    input  logic       reg_wr,
    input  logic       reg_bit,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output err_flags_t err_o,
    output logic       push_block_o
);

    typedef struct packed {
        err_flags_t flags;
    } err_state_t;

    err_state_t s_d, s_q;
    logic              rx_live_d;
    logic              ovf_ev_d;
    logic [ERR_W-1:0]  keep_d;
    logic [ERR_W-1:0]  set_d;

    always_comb begin
        rx_live_d = pwr_en & rx_en;
        ovf_ev_d  = rx_live_d & fifo_mode & rx_push & rx_full;

        // Bits to keep after the software write; zeros written clear flags.
        keep_d = '1;
        if (reg_wr) begin
            if (reg_bit) begin
                if (!reg_sel[2] && !reg_wdata[0]) begin
                    keep_d[reg_sel[1:0]] = 1'b0;
                end
            end else begin
                keep_d = reg_wdata[ERR_W-1:0];
            end
        end

        set_d = {ovf_ev_d, ev_par, ev_frm, ev_ovr} & {ERR_W{rx_live_d}};

        s_d = s_q;
        if (!rx_live_d) begin
            s_d.flags = '0;
        end else begin
            // Events override a simultaneous clear.
            s_d.flags = err_flags_t'((s_q.flags & keep_d) | set_d);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign err_o        = s_q.flags;
    assign push_block_o = ovf_ev_d;

    logic [ERR_W-1:0] err_vec;
    assign err_vec = s_q.flags;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && rx_en && !reg_wr) |=> ((err_vec & $past(err_vec)) == $past(err_vec))); // R2
    AST_ERR_CTRL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || !rx_en) |=> (err_vec == '0)); // R3
    AST_NO_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && !err_o.ovf) |=> !err_o.ovf); // R7
    AST_SUPPRESS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        push_block_o |-> (fifo_mode && rx_full && rx_push)); // R8
    AST_OVF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        push_block_o |=> err_o.ovf); // R8

endmodule

// File: rtl/sio_tx_track.sv
module sio_tx_track #(
    parameter int DEPTH = 4,
    parameter int LAG   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic tx_en,
    input  logic fifo_mode,
    input  logic tx_wr,
    input  logic tx_start,
    input  logic tx_end,
    output logic busy_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LAG-1:0]   pipe;
        logic [CNT_W-1:0] cnt;
        logic             shift;
    } tx_state_t;

    tx_state_t        s_d, s_q;
    logic             live_d;
    logic             arrive_d;
    logic             take_d;
    logic [CNT_W-1:0] cap_d;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        live_d   = pwr_en & tx_en;
        cap_d    = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
        arrive_d = s_q.pipe[LAG-1];
        take_d   = tx_start && (s_q.cnt != '0);

        cnt_d = s_q.cnt;
        if (take_d) begin
            cnt_d = cnt_d - 1'b1;
        end
        if (arrive_d && (cnt_d < cap_d)) begin
            cnt_d = cnt_d + 1'b1;
        end

        s_d      = s_q;
        s_d.pipe = (s_q.pipe << 1) | LAG'(tx_wr & live_d);
        s_d.cnt  = cnt_d;
        if (take_d) begin
            s_d.shift = 1'b1;
        end else if (tx_end) begin
            s_d.shift = 1'b0;
        end

        if (!live_d) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = ((s_q.cnt != '0) | s_q.shift) & pwr_en & tx_en;

    AST_TX_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || !tx_en) |=> (s_q.cnt == '0 && !s_q.shift && s_q.pipe == '0)); // R11
    AST_CNT_FROM_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt > $past(s_q.cnt)) |-> $past(s_q.pipe[LAG-1])); // R9
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH)); // R12

endmodule

// File: rtl/sio_status_unit.sv
module sio_status_unit
    import sio_status_pkg::*;
#(
    parameter int TX_FIFO_DEPTH = 4,
    parameter int TX_LAG        = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       fifo_mode,
    input  logic       tx_wr,
    input  logic       tx_start,
    input  logic       tx_end,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_ovr_err,
    input  logic       rx_push,
    input  logic       rx_full,
    input  logic       reg_wr,
    input  logic       reg_bit,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] stat_o,
    output logic       push_block_o
);

    err_flags_t err_w;
    logic       busy_w;

    sio_tx_track #(
        .DEPTH (TX_FIFO_DEPTH),
        .LAG   (TX_LAG)
    ) i_tx_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .tx_en     (tx_en),
        .fifo_mode (fifo_mode),
        .tx_wr     (tx_wr),
        .tx_start  (tx_start),
        .tx_end    (tx_end),
        .busy_o    (busy_w)
    );

    sio_err_flags i_err_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_en       (pwr_en),
        .rx_en        (rx_en),
        .fifo_mode    (fifo_mode),
        .ev_par       (rx_par_err),
        .ev_frm       (rx_frm_err),
        .ev_ovr       (rx_ovr_err),
        .rx_push      (rx_push),
        .rx_full      (rx_full),
        .reg_wr       (reg_wr),
        .reg_bit      (reg_bit),
        .reg_sel      (reg_sel),
        .reg_wdata    (reg_wdata),
        .err_o        (err_w),
        .push_block_o (push_block_o)
    );

    always_comb begin
        stat_o           = '0;
        stat_o[BUSY_BIT] = busy_w;
        stat_o[ERR_W-1:0] = err_w;
    end

endmodule

// File: tb/test_sio_status_unit.sv
module test_sio_status_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_en, tx_en, rx_en, fifo_mode;
    logic       tx_wr, tx_start, tx_end;
    logic       rx_par_err, rx_frm_err, rx_ovr_err, rx_push, rx_full;
    logic       reg_wr, reg_bit;
    logic [2:0] reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] stat_o;
    logic       push_block_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sio_status_unit #(.TX_FIFO_DEPTH(4), .TX_LAG(2)) i_sio_status_unit (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
        .fifo_mode(fifo_mode), .tx_wr(tx_wr), .tx_start(tx_start), .tx_end(tx_end),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_ovr_err(rx_ovr_err),
        .rx_push(rx_push), .rx_full(rx_full), .reg_wr(reg_wr), .reg_bit(reg_bit),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .stat_o(stat_o),
        .push_block_o(push_block_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulses_off();
        tx_wr = 0; tx_start = 0; tx_end = 0;
        rx_par_err = 0; rx_frm_err = 0; rx_ovr_err = 0; rx_push = 0; rx_full = 0;
        reg_wr = 0; reg_bit = 0; reg_sel = '0; reg_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Raise all four error flags (FIFO mode needed for overflow).
    task automatic set_all_errs();
        fifo_mode = 1;
        rx_par_err = 1; rx_frm_err = 1; rx_ovr_err = 1; rx_push = 1; rx_full = 1;
        #1 chk("R8 suppress same cycle", push_block_o, 1);
        tick();
        pulses_off();
        chk("R2 all flags set", stat_o, 8'h0F);
    endtask

    task automatic byte_write(input logic [7:0] d);
        reg_wr = 1; reg_bit = 0; reg_wdata = d;
        tick();
        pulses_off();
    endtask

    task automatic tx_write_wait();
        tx_wr = 1;
        tick();
        tx_wr = 0;
        tick();
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        pulses_off();
        pwr_en = 1; tx_en = 1; rx_en = 1; fifo_mode = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset value", stat_o, 8'h00);
        rst_n = 1;
        tick();
        chk("R1 after release", stat_o, 8'h00);

        // R2 sticky, positions
        set_all_errs();
        tick(); tick(); tick();
        chk("R2 sticky over idle cycles", stat_o, 8'h0F);
        for (int i = 0; i < 3; i++) begin
            byte_write(8'h00);
            case (i)
                0: rx_par_err = 1;
                1: rx_frm_err = 1;
                default: rx_ovr_err = 1;
            endcase
            tick();
            pulses_off();
            chk("R2 single flag position", stat_o, 32'h4 >> i);
        end

        // R7 overflow impossible in single mode
        byte_write(8'h00);
        fifo_mode = 0; rx_push = 1; rx_full = 1;
        #1 chk("R7 no suppress in single mode", push_block_o, 0);
        tick();
        pulses_off();
        chk("R7 overflow stays 0", stat_o[3], 0);

        // R4 byte write sweep over all patterns; upper nibble of ones ignored
        for (int w = 0; w < 16; w++) begin
            set_all_errs();
            byte_write({4'hF, w[3:0]});
            chk("R4 byte write pattern", stat_o, w);
        end

        // R5 single-bit write sweep
        for (int b = 0; b < 8; b++) begin
            for (int v = 0; v < 2; v++) begin
                set_all_errs();
                reg_wr = 1; reg_bit = 1; reg_sel = b[2:0]; reg_wdata = {7'h7F, v[0]};
                tick();
                pulses_off();
                chk("R5 bit write", stat_o,
                    (b < 4 && v == 0) ? (32'hF & ~(32'h1 << b)) : 32'hF);
            end
        end

        // R6 event wins over simultaneous clear
        set_all_errs();
        reg_wr = 1; reg_bit = 0; reg_wdata = 8'h00; rx_par_err = 1;
        tick();
        pulses_off();
        chk("R6 event beats clear", stat_o, 8'h04);

        // R3 control clears
        set_all_errs();
        pwr_en = 0;
        tick();
        pwr_en = 1;
        chk("R3 power off clears flags", stat_o, 8'h00);
        set_all_errs();
        rx_en = 0;
        tick();
        chk("R3 rx disable clears flags", stat_o, 8'h00);
        rx_par_err = 1; rx_ovr_err = 1;
        tick();
        pulses_off();
        rx_en = 1;
        chk("R3 events ignored while rx disabled", stat_o, 8'h00);
        tick();
        chk("R3 nothing latched after re-enable", stat_o, 8'h00);

        // R9 / R10 lag and busy, both modes
        for (int m = 0; m < 2; m++) begin
            fifo_mode = m[0];
            tx_wr = 1;
            #1 chk("R9 busy 0 in write cycle", stat_o[7], 0);
            tick();
            tx_wr = 0;
            chk("R9 busy 0 after edge n", stat_o[7], 0);
            tick();
            chk("R9 busy 0 after edge n+1", stat_o[7], 0);
            tick();
            chk("R9 busy 1 after edge n+2", stat_o[7], 1);
            tx_start = 1;
            tick();
            tx_start = 0;
            chk("R10 busy while shifting", stat_o[7], 1);
            tx_end = 1;
            tick();
            tx_end = 0;
            chk("R10 idle after shift done", stat_o[7], 0);
        end

        // R12 capacity per mode
        fifo_mode = 0;
        tx_wr = 1; tick(); tick(); tx_wr = 0; tick(); tick();
        tx_start = 1; tick(); tx_start = 0;
        tx_end = 1; tick(); tx_end = 0;
        chk("R12 single mode drops second write", stat_o[7], 0);
        fifo_mode = 1;
        tx_wr = 1; tick(); tick(); tx_wr = 0; tick(); tick();
        tx_start = 1; tick(); tx_start = 0;
        tx_end = 1; tick(); tx_end = 0;
        chk("R12 fifo mode keeps second write", stat_o[7], 1);
        tx_start = 1; tick(); tx_start = 0;
        tx_end = 1; tick(); tx_end = 0;
        chk("R12 fifo drained", stat_o[7], 0);

        // R11 forced zero and flush
        tx_write_wait();
        chk("R11 busy before disable", stat_o[7], 1);
        tx_en = 0;
        #1 chk("R11 busy 0 with tx disabled", stat_o[7], 0);
        tick();
        tx_en = 1;
        #1 chk("R11 pending discarded on tx disable", stat_o[7], 0);
        @(negedge clk);
        tx_write_wait();
        pwr_en = 0;
        #1 chk("R11 busy 0 with power off", stat_o[7], 0);
        tick();
        pwr_en = 1;
        #1 chk("R11 pending discarded on power off", stat_o[7], 0);
        @(negedge clk);
        tx_wr = 1; tick(); tx_wr = 0;
        tx_en = 0; tick(); tx_en = 1;
        tick(); tick();
        chk("R11 write in lag discarded", stat_o[7], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule